// File: doc/BRIEF.md
# Trimmable Real-Time Interval Timer

This block keeps wall-clock time from a 32768 Hz tick-enable pulse that arrives in the system clock domain. It holds a 23-bit tick counter. From that counter it raises a sticky interrupt at a programmable interval: a quarter second, half a second, one second, or the wrap of the whole counter. When the counter wraps, its upper byte is loaded from a programmable reload register. This lets software stretch or shorten the long wrap period without touching the sub-second part.

The counter's rate can be trimmed in steps of about half a ppm to correct crystal error. A signed trim magnitude is applied once in each window of 2^21 ticks, which is 64 s. Positive units make the counter advance by two on a tick instead of one. Negative units make it hold on a tick. The corrections are spent on the first ticks of each window.

The register ports are plain write strobes with data. Software decodes the bus elsewhere, and the oscillator and its synchroniser are outside the block.

Top module: `rtc_trim_timer`

## Requirements
- R1: While reset is held, on the next clock edge the count becomes zero, irq_pending becomes 0, the reload byte and trim become zero, and the interval select becomes 0.
- R2: On a cycle with tick_en high and no trim correction due, the count advances by exactly one.
- R3: The interval select code picks the interrupt event: 0 means bit group [LOW_W-3:0] rolls over (0.25 s), 1 means [LOW_W-2:0] rolls over (0.5 s), 2 means [LOW_W-1:0] rolls over (1 s), and 3 means the full counter wraps. Here LOW_W = CNT_W - RLD_W, which is 15 by default. A new select takes effect from the cycle after its write.
- R4: When a tick carries the counter past its all-ones value, the upper RLD_W bits load the reload byte and the low LOW_W bits keep the carried-out remainder. With no trim this remainder is zero.
- R5: Writing the reload byte never changes the running count. The new value is used only at the next wrap.
- R6: trim_data is sign and magnitude: the top bit is the direction and the lower MAG_W bits are the unit count. With the top bit 0 and magnitude m, the first m ticks of each window advance the count by two.
- R7: With the top bit 1 and magnitude m, the first m ticks of each window leave the count unchanged.
- R8: A window is 2^WIN_W ticks. Trim is sampled on the first tick of each window, so a trim write during a window affects only later windows.
- R9: A tick that advances by two and crosses an interval boundary still raises the interrupt for that boundary.
- R10: irq_pending stays set until irq_clr is high. If an interval event and irq_clr occur on the same cycle, irq_pending stays set.
- R11: With tick_en low, the count, the trim window position and irq_pending (unless it is cleared) hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per 32768 Hz period |
| reload_we | input | 1 | Write strobe for the reload byte |
| reload_data | input | RLD_W | Reload byte value |
| ivl_we | input | 1 | Write strobe for the interval select |
| ivl_sel | input | 2 | Interval select code (R3) |
| trim_we | input | 1 | Write strobe for the trim value |
| trim_data | input | MAG_W+1 | Trim: direction bit on top, magnitude below |
| irq_clr | input | 1 | Clears the pending interrupt |
| irq_pending | output | 1 | Sticky interrupt flag |
| count | output | CNT_W | Current counter value |

## Verification
A wrong window position or correction budget shows up at the count port on the first tick where the count moves by 0 or 2 instead of 1. That means a misplaced correction is visible on the very cycle it happens. A missed boundary carry or a wrong tap selection shows up only on irq_pending, one cycle after the tick that should have raised it. For that reason the interrupt flag is compared with the reference on every clock and not only at interval ends. A stale reload value stays hidden until the next wrap. The directed cases shrink the counter so that several wraps fit in the run.

// File: rtl/rtc_timer_pkg.sv
// Package: shared encodings for the trimmable interval timer.
// Assumes: nothing; holds only types.
package rtc_timer_pkg;

    // Interval select codes; the value is the interface encoding.
    typedef enum logic [1:0] {
        IVL_QUARTER = 2'd0,
        IVL_HALF    = 2'd1,
        IVL_SECOND  = 2'd2,
        IVL_WRAP    = 2'd3
    } ivl_sel_e;

    // Per-tick advance amount chosen by the trim sequencer.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_TWO  = 2'd2
    } step_e;

endpackage

// File: rtl/rtc_cfg_regs.sv
// Module: rtc_cfg_regs
// Holds the software-written configuration: the reload byte, the interval
// select and the sign-magnitude trim value.
// Assumes: write strobes are one cycle wide and the data is valid with them.
module rtc_cfg_regs
    import rtc_timer_pkg::*;
#(
    parameter int RLD_W = 8,
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_we,
    input  logic [RLD_W-1:0] reload_data,
    input  logic             ivl_we,
    input  logic [1:0]       ivl_sel,
    input  logic             trim_we,
    input  logic [MAG_W:0]   trim_data,
    output logic [RLD_W-1:0] reload_q,
    output ivl_sel_e         sel_q,
    output logic             trim_slow_q,
    output logic [MAG_W-1:0] trim_mag_q
);

    // Capture each field on its own strobe; all fields clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q    <= '0;
            sel_q       <= IVL_QUARTER;
            trim_slow_q <= 1'b0;
            trim_mag_q  <= '0;
        end else begin
            if (reload_we) begin
                reload_q <= reload_data;
            end
            if (ivl_we) begin
                sel_q <= ivl_sel_e'(ivl_sel);
            end
            if (trim_we) begin
                trim_slow_q <= trim_data[MAG_W];
                trim_mag_q  <= trim_data[MAG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rtc_trim_seq.sv
// Module: rtc_trim_seq
// Tracks the position in the trim window and spends the correction budget
// on the first ticks of each window. Each tick's step is 0, 1 or 2.
// Assumes: WIN_W > MAG_W so that a full budget fits inside one window.
module rtc_trim_seq
    import rtc_timer_pkg::*;
#(
    parameter int WIN_W = 21,
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             trim_slow,
    input  logic [MAG_W-1:0] trim_mag,
    output step_e            step,
    output logic             corr
);

    logic [WIN_W-1:0] win_q;
    logic [MAG_W-1:0] budget_q;
    logic             slow_q;
    logic             win_start;
    logic [MAG_W-1:0] avail;
    logic             dir_slow;
    logic [MAG_W-1:0] budget_next;

    // Pick the live budget: a fresh trim sample at window start, else the remainder.
    always_comb begin
        win_start   = (win_q == '0);
        avail       = win_start ? trim_mag : budget_q;
        dir_slow    = win_start ? trim_slow : slow_q;
        corr        = tick_en && (avail != '0);
        budget_next = avail - MAG_W'(corr);
        if (!corr) begin
            step = STEP_ONE;
        end else if (dir_slow) begin
            step = STEP_HOLD;
        end else begin
            step = STEP_TWO;
        end
    end

    // Advance the window and budget once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            budget_q <= '0;
            slow_q   <= 1'b0;
        end else if (tick_en) begin
            win_q    <= win_q + 1'b1;
            budget_q <= budget_next;
            if (win_start) begin
                slow_q <= trim_slow;
            end
        end
    end

endmodule

// File: rtl/rtc_count_core.sv
// Module: rtc_count_core
// The tick counter. It adds the step on each tick, reloads the upper field on
// wrap and flags the selected interval event from the carry out of the tapped
// field, so an advance by two never misses a boundary.
// Assumes: CNT_W - RLD_W >= 3.
module rtc_count_core
    import rtc_timer_pkg::*;
#(
    parameter int CNT_W = 23,
    parameter int RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  step_e            step,
    input  logic [RLD_W-1:0] reload,
    input  ivl_sel_e         sel,
    output logic [CNT_W-1:0] count,
    output logic             wrap,
    output logic             ev
);

    localparam int LOW_W  = CNT_W - RLD_W;
    localparam int N_TAPS = 3;

    logic [CNT_W-1:0]  count_q;
    logic [CNT_W:0]    sum;
    logic [N_TAPS-1:0] tap_carry;
    logic              hit;

    assign sum  = {1'b0, count_q} + (CNT_W+1)'(step);
    assign wrap = tick_en && sum[CNT_W];

    // One carry detector per sub-second tap (quarter, half, one second).
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int TAP = LOW_W - 2 + g;
        logic [TAP:0] part;
        assign part         = {1'b0, count_q[TAP-1:0]} + (TAP+1)'(step);
        assign tap_carry[g] = part[TAP];
    end

    // Select the carry for the configured interval.
    always_comb begin
        unique case (sel)
            IVL_QUARTER: hit = tap_carry[0];
            IVL_HALF:    hit = tap_carry[1];
            IVL_SECOND:  hit = tap_carry[2];
            default:     hit = sum[CNT_W];
        endcase
        ev = tick_en && hit;
    end

    // Update the counter on ticks; on wrap, load the top field and keep the remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_en) begin
            if (sum[CNT_W]) begin
                count_q <= {reload, sum[LOW_W-1:0]};
            end else begin
                count_q <= sum[CNT_W-1:0];
            end
        end
    end

    assign count = count_q;

endmodule

// File: rtl/rtc_irq_latch.sv
// Module: rtc_irq_latch
// Sticky interrupt flag: set by an event, cleared by request; an event wins
// over a clear in the same cycle.
// Assumes: ev and clr are synchronous single-cycle signals.
module rtc_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic clr,
    output logic pending
);

    // Hold, set or clear the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else begin
            pending <= ev | (pending & ~clr);
        end
    end

endmodule

// File: rtl/rtc_trim_timer.sv
// Module: rtc_trim_timer (top)
// Real-time interval timer with auto-reloaded upper field and ppm trim.
// It ties together the config registers, the trim sequencer, the counter and
// the interrupt latch.
// Assumes: tick_en is already synchronised to clk and is one cycle wide.
module rtc_trim_timer
    import rtc_timer_pkg::*;
#(
    parameter int CNT_W = 23,
    parameter int RLD_W = 8,
    parameter int WIN_W = 21,
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             reload_we,
    input  logic [RLD_W-1:0] reload_data,
    input  logic             ivl_we,
    input  logic [1:0]       ivl_sel,
    input  logic             trim_we,
    input  logic [MAG_W:0]   trim_data,
    input  logic             irq_clr,
    output logic             irq_pending,
    output logic [CNT_W-1:0] count
);

    logic [RLD_W-1:0] reload_w;
    ivl_sel_e         sel_w;
    logic             trim_slow_w;
    logic [MAG_W-1:0] trim_mag_w;
    step_e            step_w;
    logic             corr_w;
    logic             wrap_w;
    logic             ev_w;

    rtc_cfg_regs #(.RLD_W(RLD_W), .MAG_W(MAG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .reload_we(reload_we), .reload_data(reload_data),
        .ivl_we(ivl_we), .ivl_sel(ivl_sel),
        .trim_we(trim_we), .trim_data(trim_data),
        .reload_q(reload_w), .sel_q(sel_w),
        .trim_slow_q(trim_slow_w), .trim_mag_q(trim_mag_w)
    );

    rtc_trim_seq #(.WIN_W(WIN_W), .MAG_W(MAG_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .trim_slow(trim_slow_w), .trim_mag(trim_mag_w),
        .step(step_w), .corr(corr_w)
    );

    rtc_count_core #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .step(step_w), .reload(reload_w), .sel(sel_w),
        .count(count), .wrap(wrap_w), .ev(ev_w)
    );

    rtc_irq_latch u_irq (
        .clk(clk), .rst_n(rst_n), .ev(ev_w), .clr(irq_clr),
        .pending(irq_pending)
    );

endmodule

// File: rtl/rtc_trim_timer_chk.sv
// Module: rtc_trim_timer_chk
// Property checker bound to rtc_trim_timer. It relates the tick, step and
// event signals to the count and interrupt outputs.
// Assumes: reset is asserted from time zero.
module rtc_trim_timer_chk
    import rtc_timer_pkg::*;
#(
    parameter int CNT_W = 23,
    parameter int RLD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             irq_clr,
    input logic             irq_pending,
    input logic [CNT_W-1:0] count,
    input step_e            step,
    input logic             corr,
    input logic             wrap,
    input logic             ev,
    input logic [RLD_W-1:0] reload_q
);

    localparam int LOW_W = CNT_W - RLD_W;

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && step == STEP_ONE && !wrap) |=> count == CNT_W'($past(count) + 1'b1));

    a_r7_skip_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && step == STEP_HOLD) |=> $stable(count));

    a_r4_reload_top: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count[CNT_W-1:LOW_W] == $past(reload_q));

    a_r6_corr_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        corr |-> tick_en);

    a_r3_event_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ev |-> tick_en);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !irq_clr) |=> irq_pending);

    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> irq_pending);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !ev) |=> !irq_pending);

endmodule

bind rtc_trim_timer rtc_trim_timer_chk #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .irq_clr(irq_clr),
    .irq_pending(irq_pending), .count(count), .step(step_w), .corr(corr_w),
    .wrap(wrap_w), .ev(ev_w), .reload_q(reload_w)
);

// File: tb/sim_rtc_trim_timer.sv
// Bench for rtc_trim_timer, using a shrunken counter and trim window.
// A behavioural reference model is compared with the outputs on every clock,
// and directed scenarios add checks at known points.
module sim_rtc_trim_timer;

    localparam int CNT_W = 10;
    localparam int RLD_W = 4;
    localparam int WIN_W = 8;
    localparam int MAG_W = 7;
    localparam int LOW_W = CNT_W - RLD_W;
    localparam int WIN   = 1 << WIN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             reload_we = 1'b0;
    logic [RLD_W-1:0] reload_data = '0;
    logic             ivl_we = 1'b0;
    logic [1:0]       ivl_sel = '0;
    logic             trim_we = 1'b0;
    logic [MAG_W:0]   trim_data = '0;
    logic             irq_clr = 1'b0;
    logic             irq_pending;
    logic [CNT_W-1:0] count;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    rtc_trim_timer #(.CNT_W(CNT_W), .RLD_W(RLD_W), .WIN_W(WIN_W), .MAG_W(MAG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reload_we(reload_we), .reload_data(reload_data),
        .ivl_we(ivl_we), .ivl_sel(ivl_sel),
        .trim_we(trim_we), .trim_data(trim_data),
        .irq_clr(irq_clr), .irq_pending(irq_pending), .count(count)
    );

    always #4 clk = ~clk;

    // Reference model state.
    int m_cnt, m_win, m_bud, m_rld, m_sel, m_tmag;
    bit m_slow, m_tslow, m_pend, m_corr_last;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Behavioural reference, updated on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_win = 0; m_bud = 0; m_rld = 0; m_sel = 0;
            m_tmag = 0; m_slow = 0; m_tslow = 0; m_pend = 0; m_corr_last = 0;
        end else begin
            bit ev;
            bit corr;
            ev = 0;
            corr = 0;
            if (tick_en) begin
                int avail;
                int st;
                int sum;
                bit dir;
                bit ovf;
                bit carry[3];
                avail = (m_win == 0) ? m_tmag : m_bud;
                dir = (m_win == 0) ? m_tslow : m_slow;
                if (m_win == 0) m_slow = m_tslow;
                st = 1;
                if (avail > 0) begin
                    corr = 1;
                    st = dir ? 0 : 2;
                    avail--;
                end
                m_bud = avail;
                m_win = (m_win + 1) % WIN;
                for (int k = 0; k < 3; k++) begin
                    int span;
                    span = 1 << (LOW_W - 2 + k);
                    carry[k] = ((m_cnt % span) + st) >= span;
                end
                sum = m_cnt + st;
                ovf = sum >= (1 << CNT_W);
                ev = (m_sel == 3) ? ovf : carry[m_sel];
                m_cnt = ovf ? (m_rld * (1 << LOW_W) + sum % (1 << LOW_W)) : sum;
            end
            m_pend = ev | (m_pend & !irq_clr);
            m_corr_last = corr;
            if (reload_we) m_rld = reload_data;
            if (ivl_we) m_sel = ivl_sel;
            if (trim_we) begin
                m_tslow = trim_data[MAG_W];
                m_tmag = trim_data[MAG_W-1:0];
            end
        end
    end

    // Compare with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(count == CNT_W'(m_cnt), "R2 count vs model", count, m_cnt);
            check(irq_pending == m_pend, m_corr_last ? "R9 irq vs model" : "R10 irq vs model",
                  irq_pending, m_pend);
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            report();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; tick_en = 0; reload_we = 0; ivl_we = 0; trim_we = 0; irq_clr = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr_reload(input int v);
        @(negedge clk); reload_we = 1; reload_data = RLD_W'(v);
        @(negedge clk); reload_we = 0;
    endtask

    task automatic wr_sel(input int v);
        @(negedge clk); ivl_we = 1; ivl_sel = 2'(v);
        @(negedge clk); ivl_we = 0;
    endtask

    task automatic wr_trim(input bit slow, input int mag);
        @(negedge clk); trim_we = 1; trim_data = {slow, MAG_W'(mag)};
        @(negedge clk); trim_we = 0;
    endtask

    // Run n back-to-back ticks, clearing and counting each interrupt seen.
    task automatic run_ticks(input int n, output int rises);
        rises = 0;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (irq_pending) rises++;
            irq_clr = irq_pending;
            tick_en = (i < n);
        end
        @(negedge clk);
        irq_clr = 0;
    endtask

    // Run n ticks with no clearing.
    task automatic raw_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1;
        end
        @(negedge clk); tick_en = 0;
    endtask

    initial begin
        int r;
        int c0;
        do_reset();
        // R1: reset state.
        check(count == 0, "R1 count after reset", count, 0);
        check(irq_pending == 0, "R1 irq after reset", irq_pending, 0);

        // R11: no ticks, nothing moves.
        repeat (20) @(negedge clk);
        check(count == 0, "R11 idle count", count, 0);

        // R3: the three sub-second intervals (periods 16, 32, 64 here).
        run_ticks(64, r);
        check(r == 4, "R3 quarter events in 64 ticks", r, 4);
        do_reset(); wr_sel(1); run_ticks(64, r);
        check(r == 2, "R3 half events in 64 ticks", r, 2);
        do_reset(); wr_sel(2); run_ticks(64, r);
        check(r == 1, "R3 second events in 64 ticks", r, 1);
        check(count == 64, "R2 count after 64 ticks", count, 64);

        // R4: wrap reloads the top field; the next wrap is shorter.
        do_reset(); wr_sel(3); wr_reload(12);
        run_ticks(1024, r);
        check(r == 1, "R4 first wrap event", r, 1);
        check(count == 768, "R4 count after wrap", count, 768);
        run_ticks(256, r);
        check(r == 1, "R4 reloaded wrap event", r, 1);
        check(count == 768, "R4 count after second wrap", count, 768);

        // R5: reload write leaves the count alone and applies at the next wrap.
        do_reset(); wr_sel(3); wr_reload(12);
        run_ticks(100, r);
        c0 = count;
        wr_reload(14);
        check(count == c0, "R5 count unchanged by reload write", count, c0);
        run_ticks(924, r);
        check(count == 896, "R5 new reload used at wrap", count, 896);

        // R6: positive trim adds counts in one window.
        do_reset(); wr_sel(3); wr_trim(0, 5);
        run_ticks(WIN, r);
        check(count == WIN + 5, "R6 fast trim window", count, WIN + 5);

        // R7: negative trim swallows ticks.
        do_reset(); wr_sel(3); wr_trim(1, 5);
        run_ticks(WIN, r);
        check(count == WIN - 5, "R7 slow trim window", count, WIN - 5);

        // R8: a trim written mid-window waits for the next window.
        do_reset(); wr_sel(3);
        run_ticks(10, r);
        wr_trim(0, 3);
        run_ticks(WIN - 10, r);
        check(count == WIN, "R8 no correction in current window", count, WIN);
        run_ticks(WIN, r);
        check(count == 2 * WIN + 3, "R8 correction in next window", count, 2 * WIN + 3);

        // R9: double steps across quarter boundaries still raise every event.
        do_reset(); wr_trim(0, 127);
        run_ticks(128, r);
        check(count == 255, "R9 count after full fast budget", count, 255);
        check(r == 15, "R9 quarter events with double steps", r, 15);
        do_reset(); wr_trim(1, 127);
        run_ticks(128, r);
        check(count == 1, "R7 count after full slow budget", count, 1);
        check(r == 0, "R9 no spurious events while holding", r, 0);

        // R10: sticky flag, event beats clear, then clear.
        do_reset();
        raw_ticks(16);
        check(irq_pending == 1, "R10 set at quarter boundary", irq_pending, 1);
        raw_ticks(15);
        check(irq_pending == 1, "R10 sticky without clear", irq_pending, 1);
        @(negedge clk); tick_en = 1; irq_clr = 1;
        @(negedge clk); tick_en = 0; irq_clr = 0;
        check(irq_pending == 1, "R10 event wins over clear", irq_pending, 1);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        check(irq_pending == 0, "R10 cleared", irq_pending, 0);
        check(count == 32, "R11 count after mixed idle", count, 32);

        repeat (4) @(negedge clk);
        report();
    end

endmodule